// File: doc/BRIEF.md
# Paged Write Buffer Controller

This block is the write side of a byte-wide non-volatile memory. A host writes bytes through three active-low strobes: chip select, write strobe and read strobe. The block gathers the bytes into a page buffer. No command ends a load burst. The burst ends only when the host stays idle for a set time. The block then runs a fixed-length commit that copies the whole page into the storage array. Any byte position the host did not load is written as all ones.

While the commit runs, the block refuses new writes. A host read during the commit returns a status pattern instead of stored data:
- Bit 7 is the inverse of bit 7 of the last byte loaded.
- Bit 6 flips on every read access.

A ready output shows when the commit has finished. The idle timeout and the commit length are parameters counted in clock cycles. The storage array is a plain synchronous RAM inside the block.

Top module: `pgwr_ctrl`

## Requirements
- R1: A byte load happens only while chip select and write strobe are both low and the read strobe is high. A strobe pattern with the read strobe low, or with chip select high, loads nothing.
- R2: The address is taken on the clock where the load condition first becomes true, which is the later of the two strobe falls. The data is taken on the clock where the condition ends, which is the earlier of the two strobe rises.
- R3: Address bits [6:0] pick the byte within a 128-byte page. The bits above them pick the page.
- R4: If no load starts or ends for LOAD_TMO clocks after the clock that ended the last load, the commit starts. ready falls exactly then.
- R5: Every byte position of the page that was not loaded in the burst is committed as 8'hFF.
- R6: The page committed is the page of the last byte loaded. Loading a position again replaces the earlier value. Other pages are untouched.
- R7: The commit lasts exactly PROG_CYC clocks. Write strobes during the commit are ignored.
- R8: A read during the commit returns the inverse of bit 7 of the last loaded byte on bit 7. After the commit, reads return the stored byte.
- R9: During the commit, bit 6 of a read changes on every new read access, and bits 5:0 read 0. Outside the commit, repeated reads of a byte return the same value.
- R10: ready is high after reset, while idle and while loading. It is low only during the commit.
- R11: dq_oe is high only while chip select and the read strobe are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Byte address: page in the high bits, byte index in bits [6:0] |
| dq_in | input | 8 | Write data from the host |
| dq_out | output | 8 | Read data or commit status |
| dq_oe | output | 1 | Drive enable for dq_out; the bus is released when low |
| ready | output | 1 | High when no commit is running |

## Verification
Bursts are loaded with the following patterns, and each one separates a different fault:
- A single byte, which shows whether unloaded positions become all ones.
- A repeated position, which shows overwrite against keeping the first value.
- A final byte on a different page, which shows whether the last page or the first page is used.
- A strobe cycle whose address and data change while it is active, which shows the capture points.

Cycle-exact sampling of ready around the idle timeout and the commit end catches off-by-one timers. Status reads with a last byte whose bit 7 is one, and with one whose bit 7 is zero, tell true data from inverted data. Back-to-back status reads tell a per-access toggle from a stuck bit.

// File: rtl/pgwr_pkg.sv
// Shared types for the paged write buffer controller.
package pgwr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pgwr_state_e;
endpackage

// File: rtl/pgwr_strobe.sv
// Turns the host strobes into single-clock events.
// Assumes the strobes are already synchronous to clk.
module pgwr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_busy,
    output logic wr_start,
    output logic wr_end,
    output logic rd_start
);
    logic wr_q;
    logic rd_q;
    logic rd_act;

    assign wr_busy = !ce_n && !we_n && oe_n;
    assign rd_act  = !ce_n && !oe_n;

    // remember the previous level of each condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_busy;
            rd_q <= rd_act;
        end
    end

    assign wr_start = wr_busy && !wr_q;
    assign wr_end   = !wr_busy && wr_q;
    assign rd_start = rd_act && !rd_q;
endmodule

// File: rtl/pgwr_pagebuf.sv
// Page buffer: one data byte and one loaded flag per position.
// clr empties every flag; the controller never asserts clr and wr_en together.
module pgwr_pagebuf #(
    parameter int PAGE_BYTES = 128,
    localparam int IDX_W = $clog2(PAGE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [pgwr_pkg::BYTE_W-1:0] wr_data,
    input  logic                        clr,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [pgwr_pkg::BYTE_W-1:0] rd_data,
    output logic                        rd_valid
);
    logic [pgwr_pkg::BYTE_W-1:0] mem_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]       valid_q;
    logic                        live_q;

    // data storage, written on each accepted load
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    // loaded flags: cleared after a commit, set on each load
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (clr)   valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // marks that at least one clock has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assign rd_data  = mem_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    // R5: after a clear no position still counts as loaded
    p_clr_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(clr)) |-> (valid_q == '0));
endmodule

// File: rtl/pgwr_array.sv
// Storage array: single-port synchronous RAM with a registered read.
// Its contents have no reset, as a real array would.
module pgwr_array #(
    parameter int ADDR_W = 10
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [pgwr_pkg::BYTE_W-1:0] wdata,
    output logic [pgwr_pkg::BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [pgwr_pkg::BYTE_W-1:0] mem_q [DEPTH];

    // one access per clock: a write or a registered read
    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
        rdata <= mem_q[addr];
    end
endmodule

// File: rtl/pgwr_ctrl.sv
// Paged write controller. It loads bytes into a page buffer, starts a commit
// after LOAD_TMO idle clocks, and copies the page into the array over PROG_CYC
// clocks, writing unloaded positions as all ones. While the commit runs, reads
// return status bits. Host strobes are assumed synchronous to clk.
module pgwr_ctrl #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 128,
    parameter int LOAD_TMO   = 40000,
    parameter int PROG_CYC   = 1000000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce_n,
    input  logic                        we_n,
    input  logic                        oe_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [pgwr_pkg::BYTE_W-1:0] dq_in,
    output logic [pgwr_pkg::BYTE_W-1:0] dq_out,
    output logic                        dq_oe,
    output logic                        ready
);
    import pgwr_pkg::*;

    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - IDX_W;
    localparam int LT_W  = $clog2(LOAD_TMO + 1);
    localparam int PC_W  = $clog2(PROG_CYC + 1);
    localparam logic [LT_W-1:0] LT_LAST  = LT_W'(LOAD_TMO - 1);
    localparam logic [PC_W-1:0] PC_LAST  = PC_W'(PROG_CYC - 1);
    localparam logic [PC_W-1:0] PC_PAGE  = PC_W'(PAGE_BYTES);

    initial assert (PROG_CYC >= PAGE_BYTES && LOAD_TMO >= 1);

    pgwr_state_e        st;
    logic [LT_W-1:0]    ltmr;
    logic [PC_W-1:0]    pcnt;
    logic [ADDR_W-1:0]  addr_q;
    logic [PG_W-1:0]    page_q;
    logic               last_d7;
    logic               tgl;
    logic               live_q;

    logic wr_busy, wr_start, wr_end, rd_start;
    logic load_ok;
    logic [BYTE_W-1:0]  buf_data;
    logic               buf_valid;
    logic               arr_we;
    logic [ADDR_W-1:0]  arr_addr;
    logic [BYTE_W-1:0]  arr_wdata;
    logic [BYTE_W-1:0]  arr_rdata;

    pgwr_strobe strobe_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wr_busy(wr_busy), .wr_start(wr_start), .wr_end(wr_end),
        .rd_start(rd_start)
    );

    assign load_ok = wr_end && (st != ST_PROG);

    pgwr_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) pagebuf_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(load_ok), .wr_idx(addr_q[IDX_W-1:0]), .wr_data(dq_in),
        .clr((st == ST_PROG) && (pcnt == PC_LAST)),
        .rd_idx(pcnt[IDX_W-1:0]), .rd_data(buf_data), .rd_valid(buf_valid)
    );

    assign arr_we    = (st == ST_PROG) && (pcnt < PC_PAGE);
    assign arr_addr  = (st == ST_PROG) ? {page_q, pcnt[IDX_W-1:0]} : addr;
    assign arr_wdata = buf_valid ? buf_data : {BYTE_W{1'b1}};

    pgwr_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .we(arr_we), .addr(arr_addr),
        .wdata(arr_wdata), .rdata(arr_rdata)
    );

    // address capture when a write cycle becomes active
    always_ff @(posedge clk) begin
        if (!rst_n)                              addr_q <= '0;
        else if (wr_start && (st != ST_PROG))    addr_q <= addr;
    end

    // page latch and polarity bit follow each accepted load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            last_d7 <= 1'b0;
        end else if (load_ok) begin
            page_q  <= addr_q[ADDR_W-1:IDX_W];
            last_d7 <= dq_in[BYTE_W-1];
        end
    end

    // sequencer: idle, loading with idle timeout, timed commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            ltmr <= '0;
            pcnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (load_ok) begin
                        st   <= ST_LOAD;
                        ltmr <= '0;
                    end
                end
                ST_LOAD: begin
                    if (load_ok || wr_busy) begin
                        ltmr <= '0;
                    end else if (ltmr == LT_LAST) begin
                        st   <= ST_PROG;
                        pcnt <= '0;
                    end else begin
                        ltmr <= ltmr + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (pcnt == PC_LAST) begin
                        st   <= ST_IDLE;
                        ltmr <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // status toggle flips once per read access during a commit
    always_ff @(posedge clk) begin
        if (!rst_n)                          tgl <= 1'b0;
        else if (rd_start && (st == ST_PROG)) tgl <= ~tgl;
    end

    // marks that at least one clock has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // read path: stored byte or commit status
    always_comb begin
        dq_oe = !ce_n && !oe_n;
        if (!dq_oe)              dq_out = '0;
        else if (st == ST_PROG)  dq_out = {~last_d7, tgl, {(BYTE_W-2){1'b0}}};
        else                     dq_out = arr_rdata;
    end

    assign ready = (st != ST_PROG);

    // R4: a commit is entered only from loading after the full idle count
    p_prog_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && st == ST_PROG && $past(st) != ST_PROG)
        |-> ($past(st) == ST_LOAD && $past(ltmr) == LT_LAST));

    // R6: the committed page stays fixed through the commit
    p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && st == ST_PROG && $past(st) == ST_PROG) |-> $stable(page_q));

    // R7: the commit counter never passes its last value
    p_prog_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |-> (pcnt <= PC_LAST));

    // R7: a write strobe during a commit leaves the polarity bit alone
    p_ignore_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(st) == ST_PROG && $past(wr_end)) |-> $stable(last_d7));

    // R9: the toggle bit is frozen outside a commit
    p_tgl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && st != ST_PROG && $past(st) != ST_PROG) |-> $stable(tgl));
endmodule

// File: tb/pgwr_ctrl_tb.sv
// Directed bench for pgwr_ctrl: one task per scenario.
module pgwr_ctrl_tb_top;
    localparam int ADDR_W = 10;
    localparam int TMO    = 64;
    localparam int PCYC   = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic       ready;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pgwr_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(128), .LOAD_TMO(TMO), .PROG_CYC(PCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ready(ready)
    );

    function automatic logic [ADDR_W-1:0] mk(input int page, input int idx);
        return ADDR_W'(page * 128 + idx);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd_byte(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        d = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 2000 && ready; i++) @(negedge clk);
    endtask

    task automatic wait_commit();
        wait_busy();
        for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
    endtask

    task automatic expect_byte(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string req);
        logic [7:0] d;
        logic oe;
        rd_byte(a, d, oe);
        check(oe && d == e, req, int'(d), int'(e));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(ready == 1'b1, "R10 reset ready", int'(ready), 1);
        check(dq_oe == 1'b0, "R11 reset dq_oe", int'(dq_oe), 0);
    endtask

    task automatic t_timing();
        wr_byte(mk(2, 0), 8'h12);
        for (int k = 1; k <= TMO + 1; k++) begin
            @(negedge clk);
            if (k == TMO)     check(ready == 1'b1, "R4 before timeout", int'(ready), 1);
            if (k == TMO + 1) check(ready == 1'b0, "R4 at timeout", int'(ready), 0);
        end
        repeat (PCYC - 1) @(negedge clk);
        check(ready == 1'b0, "R7 last commit clock", int'(ready), 0);
        @(negedge clk);
        check(ready == 1'b1, "R10 ready after commit", int'(ready), 1);
        expect_byte(mk(2, 0), 8'h12, "R8 stored byte");
        expect_byte(mk(2, 1), 8'hFF, "R5 unloaded byte");
    endtask

    task automatic t_page();
        logic [7:0] d;
        logic oe;
        wr_byte(mk(3, 5), 8'hA5);
        wr_byte(mk(3, 5), 8'h3C);
        wr_byte(mk(3, 127), 8'h81);
        wr_byte(mk(5, 0), 8'hC4);
        wait_busy();
        rd_byte(mk(5, 0), d, oe);
        check(d[7] == 1'b0, "R8 inverted bit7 (one)", int'(d[7]), 0);
        wait_commit();
        expect_byte(mk(5, 5), 8'h3C, "R6 overwrite on last page");
        expect_byte(mk(5, 127), 8'h81, "R3 top index");
        expect_byte(mk(5, 0), 8'hC4, "R3 index zero");
        expect_byte(mk(5, 6), 8'hFF, "R5 unloaded byte");
        expect_byte(mk(2, 0), 8'h12, "R6 other page kept");
    endtask

    task automatic t_inhibit();
        int low = 0;
        @(negedge clk);
        addr = mk(2, 0); dq_in = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        for (int k = 0; k < TMO + 10; k++) begin
            @(negedge clk);
            if (!ready) low++;
        end
        check(low == 0, "R1 no commit from inhibited strobes", low, 0);
        expect_byte(mk(2, 0), 8'h12, "R1 byte unchanged");
    endtask

    task automatic t_capture();
        @(negedge clk);
        addr = mk(6, 2); dq_in = 8'h01; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        addr = mk(6, 9); dq_in = 8'h7E;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1; dq_in = 8'h33;
        wait_commit();
        expect_byte(mk(6, 2), 8'h7E, "R2 address at start, data at end");
        expect_byte(mk(6, 9), 8'hFF, "R2 later address not used");
    endtask

    task automatic t_status();
        logic [7:0] d1, d2;
        logic oe1, oe2;
        wr_byte(mk(7, 3), 8'h5A);
        wait_busy();
        rd_byte(mk(7, 3), d1, oe1);
        check(oe1 == 1'b1, "R11 driven on read", int'(oe1), 1);
        check(d1[7] == 1'b1, "R8 inverted bit7 (zero)", int'(d1[7]), 1);
        check(d1[5:0] == 6'd0, "R9 low status bits", int'(d1[5:0]), 0);
        rd_byte(mk(7, 3), d2, oe2);
        check(d2[6] != d1[6], "R9 toggle per access", int'(d2[6]), int'(~d1[6]));
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 1'b0, "R11 released with oe_n high", int'(dq_oe), 0);
        ce_n = 1'b1;
        wr_byte(mk(7, 4), 8'h00);
        @(negedge clk);
        check(ready == 1'b0, "R10 busy during commit", int'(ready), 0);
        for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
        expect_byte(mk(7, 3), 8'h5A, "R8 true data after commit");
        expect_byte(mk(7, 3), 8'h5A, "R9 stable after commit");
        expect_byte(mk(7, 4), 8'hFF, "R7 write during commit ignored");
        repeat (TMO + 5) @(negedge clk);
        check(ready == 1'b1, "R7 no second commit", int'(ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_page();
        t_inhibit();
        t_capture();
        t_status();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule